// File: doc/BRIEF.md
# Processor clock divider and startup sequencer

This block turns an oscillator input running at twice the core rate into the processor clock. It also handles startup after an active-low reset pin. The output clock toggles on every falling edge of the oscillator, which gives a symmetric clock at half the oscillator frequency.

While the reset pin is low, the core is held idle and bus activity is inhibited. During that time a load strobe tells the core to take the fixed power-up values of its architectural registers, which the block presents as constant buses. The pin is first synchronized into the output-clock domain. After release, a fixed number of output-clock cycles must pass before the run enable rises. The first fetch then goes to the physical boot address, which is formed from the power-up code segment and instruction pointer.

Top module: `clkgen_boot`

## Requirements
- R1: Out of reset, `clkout_o` toggles on every falling edge of `osc_i` and on no other event, so it runs at half the oscillator rate with a 50% duty cycle.
- R2: While `rst_pin_n` is low, `clkout_o` is held low. After release, its first rising edge comes at the first falling edge of `osc_i`.
- R3: The reset pin passes through two flops clocked by rising edges of `clkout_o`. `reg_load_o` is high while the synchronized reset is active, and it falls at the second rising edge of `clkout_o` after release.
- R4: `core_run_o` is low during reset and rises at rising edge START_DELAY+2 of `clkout_o` after release (edge 8 with the default START_DELAY of 6). Once high, it stays high until the next reset.
- R5: `bus_hold_o` is high exactly when `core_run_o` is low.
- R6: Driving `rst_pin_n` low takes effect at once, with no clock edge needed: `reg_load_o` goes high, `core_run_o` goes low and `bus_hold_o` goes high.
- R7: The power-up values are: status word (`init_flags_o`) F002h, instruction pointer 0000h, code segment FFFFh, and data, extra and stack segments 0000h.
- R8: The power-up value of the relocation register is 20FFh and of the upper-memory chip-select register is FFFBh.
- R9: `boot_addr_o` equals the code segment times 16 plus the instruction pointer, which is FFFF0h.
- R10: A reset pulse during the startup interval restarts the full synchronization and delay count from the later release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_i | input | 1 | Oscillator at twice the core rate |
| rst_pin_n | input | 1 | Active-low reset pin, asynchronous |
| clkout_o | output | 1 | Processor clock, oscillator divided by two |
| core_run_o | output | 1 | Core may execute |
| bus_hold_o | output | 1 | Bus cycles inhibited |
| reg_load_o | output | 1 | Core loads power-up register values |
| init_flags_o | output | 16 | Power-up status word |
| init_ip_o | output | 16 | Power-up instruction pointer |
| init_cs_o | output | 16 | Power-up code segment |
| init_ds_o | output | 16 | Power-up data segment |
| init_es_o | output | 16 | Power-up extra segment |
| init_ss_o | output | 16 | Power-up stack segment |
| init_reloc_o | output | 16 | Power-up relocation register |
| init_upcs_o | output | 16 | Power-up upper-memory chip-select register |
| boot_addr_o | output | 20 | Physical address of the first fetch |

## Verification
A divider that slips a phase shows up on `clkout_o` within one oscillator period, because every falling edge must produce a toggle. A synchronizer stage that is missing or extra moves the fall of `reg_load_o` by one output-clock cycle. A counter that is off by one moves the rise of `core_run_o` by a whole cycle. The bench compares every output against a behavioural model on each oscillator period, so any of these faults is reported within one cycle. A reset pulse that fails to clear the count shows up as an early run enable after the second release.

// File: rtl/clkgen_boot_pkg.sv
package clkgen_boot_pkg;
  localparam int WORD_W = 16;
  localparam int PHYS_W = 20;

  localparam logic [WORD_W-1:0] PWR_FLAGS = 16'hF002;
  localparam logic [WORD_W-1:0] PWR_IP    = 16'h0000;
  localparam logic [WORD_W-1:0] PWR_CS    = 16'hFFFF;
  localparam logic [WORD_W-1:0] PWR_DS    = 16'h0000;
  localparam logic [WORD_W-1:0] PWR_ES    = 16'h0000;
  localparam logic [WORD_W-1:0] PWR_SS    = 16'h0000;
  localparam logic [WORD_W-1:0] PWR_RELOC = 16'h20FF;
  localparam logic [WORD_W-1:0] PWR_UPCS  = 16'hFFFB;

  // Segment:offset to physical address (segment shifted left by four).
  function automatic logic [PHYS_W-1:0] seg_to_phys(
    input logic [WORD_W-1:0] seg,
    input logic [WORD_W-1:0] off
  );
    return {seg, 4'h0} + {4'h0, off};
  endfunction
endpackage

// File: rtl/clkgen_div2.sv
module clkgen_div2 (
  input  logic osc_i,
  input  logic rst_n,
  output logic clk_o
);
  logic clk_q;
  logic clk_d;

  always_comb begin
    clk_d = ~clk_q;
  end

  // State advances on the falling oscillator edge.
  always_ff @(negedge osc_i or negedge rst_n) begin
    if (!rst_n) clk_q <= 1'b0;
    else        clk_q <= clk_d;
  end

  assign clk_o = clk_q;

  // R1: every falling oscillator edge out of reset flips the output
  p_toggle_each_edge_r1: assert property (@(negedge osc_i) disable iff (!rst_n)
    1'b1 |=> (clk_o != $past(clk_o)));
endmodule

// File: rtl/clkgen_rst_sync.sv
module clkgen_rst_sync #(
  parameter int STAGES = 2  // at least 2
) (
  input  logic clk_i,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sq_q;
  logic [STAGES-1:0] sq_d;

  always_comb begin
    sq_d = {sq_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) sq_q <= '0;
    else        sq_q <= sq_d;
  end

  assign rst_sync_n = sq_q[STAGES-1];

  // R3: the last stage only rises after the stage before it was high
  p_sync_order_r3: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(rst_sync_n) |-> $past(sq_q[STAGES-2]));
endmodule

// File: rtl/clkgen_start_ctr.sv
module clkgen_start_ctr #(
  parameter int DELAY = 6,
  localparam int CW = $clog2(DELAY + 1)
) (
  input  logic clk_i,
  input  logic rst_n,
  output logic run_o,
  output logic hold_o
);
  localparam logic [CW-1:0] LAST = CW'(DELAY - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          run_q, run_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = ~run_q;
    cnt_d  = cnt_q;
    run_d  = run_q;
    if (cnt_en) begin
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == LAST) run_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      run_q <= run_d;
    end
  end

  assign run_o  = run_q;
  assign hold_o = ~run_q;

  // R4: run enable is sticky until reset
  p_run_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_n)
    run_o |=> run_o);
  // R4: run enable only rises when the count has just expired
  p_run_after_count_r4: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(run_o) |-> ($past(cnt_q) == LAST));
  // R6: no run while the synchronized reset is active
  p_idle_in_reset_r6: assert property (@(posedge clk_i)
    !rst_n |-> !run_o);
endmodule

// File: rtl/clkgen_boot.sv
module clkgen_boot
  import clkgen_boot_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int START_DELAY = 6
) (
  input  logic              osc_i,
  input  logic              rst_pin_n,
  output logic              clkout_o,
  output logic              core_run_o,
  output logic              bus_hold_o,
  output logic              reg_load_o,
  output logic [WORD_W-1:0] init_flags_o,
  output logic [WORD_W-1:0] init_ip_o,
  output logic [WORD_W-1:0] init_cs_o,
  output logic [WORD_W-1:0] init_ds_o,
  output logic [WORD_W-1:0] init_es_o,
  output logic [WORD_W-1:0] init_ss_o,
  output logic [WORD_W-1:0] init_reloc_o,
  output logic [WORD_W-1:0] init_upcs_o,
  output logic [PHYS_W-1:0] boot_addr_o
);
  logic clk_core;
  logic rst_core_n;

  clkgen_div2 u_div (
    .osc_i (osc_i),
    .rst_n (rst_pin_n),
    .clk_o (clk_core)
  );

  clkgen_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_core),
    .rst_n      (rst_pin_n),
    .rst_sync_n (rst_core_n)
  );

  clkgen_start_ctr #(.DELAY(START_DELAY)) u_ctr (
    .clk_i  (clk_core),
    .rst_n  (rst_core_n),
    .run_o  (core_run_o),
    .hold_o (bus_hold_o)
  );

  assign clkout_o     = clk_core;
  assign reg_load_o   = ~rst_core_n;
  assign init_flags_o = PWR_FLAGS;
  assign init_ip_o    = PWR_IP;
  assign init_cs_o    = PWR_CS;
  assign init_ds_o    = PWR_DS;
  assign init_es_o    = PWR_ES;
  assign init_ss_o    = PWR_SS;
  assign init_reloc_o = PWR_RELOC;
  assign init_upcs_o  = PWR_UPCS;
  assign boot_addr_o  = seg_to_phys(PWR_CS, PWR_IP);

  // R5: bus is never released while the core is not running
  p_bus_held_r5: assert property (@(posedge clk_core) disable iff (!rst_pin_n)
    !core_run_o |-> bus_hold_o);
  // R3: register load is over before the core may run
  p_load_before_run_r3: assert property (@(posedge clk_core) disable iff (!rst_pin_n)
    core_run_o |-> !reg_load_o);
  // R2: output clock stays low throughout a pin reset
  p_clk_low_in_reset_r2: assert property (@(posedge osc_i)
    !rst_pin_n |-> !clkout_o);
endmodule

// File: tb/clkgen_boot_bench.sv
`timescale 1ns/1ps
module clkgen_boot_bench;
  localparam int DLY = 6;

  logic        osc = 1'b0;
  logic        rst_pin_n = 1'b0;
  logic        clkout, run, hold, load;
  logic [15:0] flags, ip, cs, ds, es, ss, reloc, upcs;
  logic [19:0] baddr;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // Reference model state
  bit m_clk = 0;
  int m_edges = 0;

  always #2.5 osc = ~osc;

  clkgen_boot #(.SYNC_STAGES(2), .START_DELAY(DLY)) u_clkgen_boot (
    .osc_i(osc), .rst_pin_n(rst_pin_n), .clkout_o(clkout),
    .core_run_o(run), .bus_hold_o(hold), .reg_load_o(load),
    .init_flags_o(flags), .init_ip_o(ip), .init_cs_o(cs),
    .init_ds_o(ds), .init_es_o(es), .init_ss_o(ss),
    .init_reloc_o(reloc), .init_upcs_o(upcs), .boot_addr_o(baddr)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  // Model: divider toggles on falling osc edges, counts rising edges since release
  always @(negedge osc) begin
    if (!rst_pin_n) begin
      m_clk = 0; m_edges = 0;
    end else begin
      m_clk = !m_clk;
      if (m_clk) m_edges++;
    end
  end
  always @(negedge rst_pin_n) begin
    m_clk = 0; m_edges = 0;
  end

  // Compare away from the falling edge where the design updates
  always @(posedge osc) begin
    #1;
    if (!done) begin
      automatic bit e_load = !rst_pin_n || (m_edges < 2);
      automatic bit e_run  = rst_pin_n && (m_edges >= DLY + 2);
      chk(clkout == m_clk, "R1/R2 clkout", 32'(clkout), 32'(m_clk));
      chk(load == e_load, "R3 reg_load", 32'(load), 32'(e_load));
      chk(run == e_run, "R4/R10 core_run", 32'(run), 32'(e_run));
      chk(hold == !e_run, "R5 bus_hold", 32'(hold), 32'(!e_run));
      chk(flags == 16'hF002 && ip == 16'h0000 && cs == 16'hFFFF,
          "R7 flags/ip/cs", {flags, cs}, 32'hF002FFFF);
      chk(ds == 16'h0 && es == 16'h0 && ss == 16'h0 && ip == 16'h0,
          "R7 ds/es/ss", {ds | es, ss | ip}, 32'h0);
      chk(reloc == 16'h20FF && upcs == 16'hFFFB, "R8 reloc/upcs",
          {reloc, upcs}, 32'h20FFFFFB);
      chk(baddr == 20'hFFFF0, "R9 boot address", 32'(baddr), 32'hFFFF0);
    end
  end

  task automatic osc_cycles(input int n);
    for (int i = 0; i < n; i++) @(posedge osc);
  endtask

  // R6: pin assertion acts without a clock edge
  task automatic async_reset_check();
    @(posedge osc);
    #2;
    rst_pin_n = 1'b0;
    #0.2;
    chk(load == 1'b1, "R6 load at once", 32'(load), 32'h1);
    chk(run == 1'b0, "R6 run drops at once", 32'(run), 32'h0);
    chk(hold == 1'b1, "R6 hold at once", 32'(hold), 32'h1);
  endtask

  task automatic release_pin();
    @(posedge osc);
    #2;
    rst_pin_n = 1'b1;
  endtask

  initial begin
    #3;
    chk(clkout == 1'b0, "R2 reset clkout", 32'(clkout), 32'h0);
    chk(run == 1'b0 && hold == 1'b1 && load == 1'b1, "R6 reset state",
        {29'h0, run, hold, load}, 32'h3);
    osc_cycles(10);
    release_pin();
    osc_cycles(40);
    async_reset_check();
    osc_cycles(6);
    release_pin();
    osc_cycles(6);             // R10: pulse in the middle of startup
    async_reset_check();
    osc_cycles(2);
    release_pin();
    osc_cycles(9);             // R10: early run would appear here
    chk(run == 1'b0, "R10 restarted count", 32'(run), 32'h0);
    osc_cycles(40);
    async_reset_check();
    osc_cycles(3);
    release_pin();
    osc_cycles(30);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule